// File: doc/BRIEF.md
# Multichip Interrupt Routing Configuration Sequencer

This block is a small hardware sequencer that brings a multi-socket interrupt distributor on line. On a start pulse it acts as a register-bus master with one transaction in flight. First it confirms that the distributor is quiescent and that its routing table is disconnected. Then it claims routing-table ownership. After that it programs one chip descriptor register per socket. The socket that owns the routing table is always programmed first, and the other sockets follow in ascending order.

Every write sits between polls of a busy flag, and each poll run is bounded by a retry limit. Every descriptor write is read back and compared with the value written. After each socket, the routing-state field must report a consistent table. The outcome stays on `done` and a 3-bit `err_code` until the next start pulse.

The configuration inputs are a chip count, an owner index, and three flat per-chip tables: a 16-bit chip address, a lowest SPI ID and a highest SPI ID. These inputs must stay stable while `busy` is high.

Top module: `mc_route_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are 0 and `err_code` is 0.
- R2: The first transaction is a read of the control register at 0x000. If any of bits 0, 1, 2 or 31 is set, the run ends with `err_code` 1 and no write is issued.
- R3: The second transaction is a read of the status register at 0x010. If bits [1:0] are not 00 (disconnected), the run ends with `err_code` 2 and no write is issued.
- R4: Every write is preceded and followed by reads of the owner register at 0x014 until bit 0 (update busy) reads 0. A poll run makes at most RETRY+1 reads. If bit 0 is still 1 on the last of them, the run ends with `err_code` 3.
- R5: The first write goes to 0x014. Its value is the last value read there with the owner index OR-ed in at bit 4 upward.
- R6: Descriptor writes go to 0x040 + 4·n. The owner index n is written first. Every other n below `chip_count` follows in ascending order, with the owner skipped. On success `done`=1 and `err_code`=0.
- R7: A descriptor value carries the chip address in [31:16], the block count (max−min+1)/32 in [15:8], the first block (min−32)/32 in [7:1], and bit 0 (online) set to 1.
- R8: An entry whose min and max are both 0 is encoded as if both were 32, which gives block count 0 and first block 0.
- R9: After each descriptor write and its trailing poll, the descriptor is read back. Any difference from the written value ends the run with `err_code` 4.
- R10: After each readback, the status register is read. If bits [1:0] are not 01 (consistent), the run ends with `err_code` 5.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged.
- R12: `done` and `err_code` hold until the next start pulse, which clears both. A start pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| chip_count | input | CW | Number of sockets to program |
| owner_idx | input | IW | Routing-table owner index |
| chip_addr_tbl | input | MAX_CHIPS·16 | Per-chip address fields |
| spi_lo_tbl | input | MAX_CHIPS·SPI_W | Per-chip lowest SPI ID |
| spi_hi_tbl | input | MAX_CHIPS·SPI_W | Per-chip highest SPI ID |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | Write when 1, read when 0 |
| bus_addr | output | 12 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction complete, read data valid |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held |
| err_code | output | 3 | 0 success, 1..5 failure cause, held |

## Verification
The bench sweeps every chip count and every owner position. It checks the write order and the encoded values, including an owner in the middle of the range. A design that failed to skip the owner would write that socket twice. A design that started from index 0 would put the owner's descriptor out of place. Busy-flag runs of exactly RETRY and RETRY+1 set reads target the retry boundary, where an off-by-one either times out a legal sequence or lets a stuck flag through. Error injection at each check point confirms that the sequence stops with the right code and the right number of writes. A stray start pulse during a run must not restart the sequence or clear the log.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int BUS_AW    = 12;
  localparam int BUS_DW    = 32;
  localparam int CHIP_AW   = 16;
  localparam int FIRST_SPI = 32;

  localparam logic [BUS_AW-1:0] A_CTRL  = 12'h000;
  localparam logic [BUS_AW-1:0] A_STAT  = 12'h010;
  localparam logic [BUS_AW-1:0] A_OWNER = 12'h014;
  localparam logic [BUS_AW-1:0] A_CHIP0 = 12'h040;

  localparam logic [BUS_DW-1:0] CTRL_BLOCK_MASK = 32'h8000_0007;
  localparam int                BUSY_BIT  = 0;
  localparam int                OWNER_SH  = 4;
  localparam logic [1:0]        RS_DISC   = 2'b00;
  localparam logic [1:0]        RS_CONS   = 2'b01;

  localparam logic [2:0] E_NONE    = 3'd0;
  localparam logic [2:0] E_ACTIVE  = 3'd1;
  localparam logic [2:0] E_NOTDISC = 3'd2;
  localparam logic [2:0] E_TIMEOUT = 3'd3;
  localparam logic [2:0] E_RBACK   = 3'd4;
  localparam logic [2:0] E_INCONS  = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_STAT0, S_POLL, S_WOWN, S_WCHIP, S_RBACK, S_STAT1
  } seq_state_e;

  typedef enum logic [1:0] {
    P_PRE_OWN, P_POST_OWN, P_PRE_CHIP, P_POST_CHIP
  } poll_ret_e;
endpackage

// File: rtl/mcr_retry_ctr.sv
module mcr_retry_ctr #(
  parameter int RETRY = 1000,
  localparam int RCW = $clog2(RETRY + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic zero
);
  logic [RCW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = RCW'(RETRY);
    else if (dec)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load || dec)  cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/mcr_chip_enc.sv
module mcr_chip_enc import mcr_pkg::*; #(
  parameter int MAX_CHIPS = 4,
  parameter int SPI_W     = 10,
  localparam int IW = (MAX_CHIPS > 1) ? $clog2(MAX_CHIPS) : 1
) (
  input  logic [IW-1:0]                idx,
  input  logic [MAX_CHIPS*CHIP_AW-1:0] addr_tbl,
  input  logic [MAX_CHIPS*SPI_W-1:0]   lo_tbl,
  input  logic [MAX_CHIPS*SPI_W-1:0]   hi_tbl,
  output logic [BUS_DW-1:0]            value
);
  logic [CHIP_AW-1:0] caddr;
  logic [SPI_W-1:0]   lo_raw, hi_raw, lo, hi, off;
  logic [SPI_W:0]     span;
  logic [6:0]         first_blk;
  logic [7:0]         n_blk;

  always_comb begin
    caddr  = addr_tbl[idx*CHIP_AW +: CHIP_AW];
    lo_raw = lo_tbl[idx*SPI_W +: SPI_W];
    hi_raw = hi_tbl[idx*SPI_W +: SPI_W];
    if (lo_raw == '0 && hi_raw == '0) begin
      lo = SPI_W'(FIRST_SPI);
      hi = SPI_W'(FIRST_SPI);
    end else begin
      lo = lo_raw;
      hi = hi_raw;
    end
    off       = lo - SPI_W'(FIRST_SPI);
    span      = {1'b0, hi} - {1'b0, lo} + 1'b1;
    first_blk = 7'(off >> 5);
    n_blk     = 8'(span >> 5);
    value     = {caddr, n_blk, first_blk, 1'b1};
  end
endmodule

// File: rtl/mcr_chip_order.sv
module mcr_chip_order #(
  parameter int MAX_CHIPS = 4,
  localparam int IW = (MAX_CHIPS > 1) ? $clog2(MAX_CHIPS) : 1,
  localparam int CW = $clog2(MAX_CHIPS + 2)
) (
  input  logic [CW-1:0] cur,
  input  logic          owner_phase,
  input  logic [IW-1:0] owner,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] nxt,
  output logic          last
);
  logic [CW-1:0] base;

  always_comb begin
    base = owner_phase ? '0 : cur + 1'b1;
    nxt  = (base == CW'(owner)) ? base + 1'b1 : base;
    last = (nxt >= count);
  end
endmodule

// File: rtl/mc_route_seq.sv
module mc_route_seq import mcr_pkg::*; #(
  parameter int MAX_CHIPS = 4,
  parameter int SPI_W     = 10,
  parameter int RETRY     = 1000,
  localparam int IW = (MAX_CHIPS > 1) ? $clog2(MAX_CHIPS) : 1,
  localparam int CW = $clog2(MAX_CHIPS + 2)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [CW-1:0]                chip_count,
  input  logic [IW-1:0]                owner_idx,
  input  logic [MAX_CHIPS*CHIP_AW-1:0] chip_addr_tbl,
  input  logic [MAX_CHIPS*SPI_W-1:0]   spi_lo_tbl,
  input  logic [MAX_CHIPS*SPI_W-1:0]   spi_hi_tbl,
  output logic                         bus_req,
  output logic                         bus_we,
  output logic [BUS_AW-1:0]            bus_addr,
  output logic [BUS_DW-1:0]            bus_wdata,
  input  logic                         bus_ack,
  input  logic [BUS_DW-1:0]            bus_rdata,
  output logic                         busy,
  output logic                         done,
  output logic [2:0]                   err_code
);
  seq_state_e         st_q, st_d;
  poll_ret_e          ret_q, ret_d;
  logic [CW-1:0]      cur_q, cur_d;
  logic               first_q, first_d;
  logic [BUS_DW-1:0]  last_q, last_d;
  logic               done_q, done_d;
  logic [2:0]         err_q, err_d;

  logic               pc_load, pc_dec, pc_zero;
  logic [BUS_DW-1:0]  desc_val;
  logic [CW-1:0]      nxt_idx;
  logic               nxt_last;
  logic [BUS_AW-1:0]  desc_addr;

  mcr_retry_ctr #(.RETRY(RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .load(pc_load), .dec(pc_dec), .zero(pc_zero)
  );

  mcr_chip_enc #(.MAX_CHIPS(MAX_CHIPS), .SPI_W(SPI_W)) u_enc (
    .idx(cur_q[IW-1:0]), .addr_tbl(chip_addr_tbl),
    .lo_tbl(spi_lo_tbl), .hi_tbl(spi_hi_tbl), .value(desc_val)
  );

  mcr_chip_order #(.MAX_CHIPS(MAX_CHIPS)) u_order (
    .cur(cur_q), .owner_phase(first_q), .owner(owner_idx),
    .count(chip_count), .nxt(nxt_idx), .last(nxt_last)
  );

  assign desc_addr = A_CHIP0 + (BUS_AW'(cur_q) << 2);

  always_comb begin
    st_d      = st_q;
    ret_d     = ret_q;
    cur_d     = cur_q;
    first_d   = first_q;
    last_d    = last_q;
    done_d    = done_q;
    err_d     = err_q;
    pc_load   = 1'b0;
    pc_dec    = 1'b0;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;

    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d   = S_CTRL;
          done_d = 1'b0;
          err_d  = E_NONE;
        end
      end
      S_CTRL: begin
        bus_req  = 1'b1;
        bus_addr = A_CTRL;
        if (bus_ack) begin
          if ((bus_rdata & CTRL_BLOCK_MASK) != '0) begin
            st_d = S_IDLE; done_d = 1'b1; err_d = E_ACTIVE;
          end else begin
            st_d = S_STAT0;
          end
        end
      end
      S_STAT0: begin
        bus_req  = 1'b1;
        bus_addr = A_STAT;
        if (bus_ack) begin
          if (bus_rdata[1:0] != RS_DISC) begin
            st_d = S_IDLE; done_d = 1'b1; err_d = E_NOTDISC;
          end else begin
            st_d = S_POLL; ret_d = P_PRE_OWN; pc_load = 1'b1;
          end
        end
      end
      S_POLL: begin
        bus_req  = 1'b1;
        bus_addr = A_OWNER;
        if (bus_ack) begin
          if (!bus_rdata[BUSY_BIT]) begin
            last_d = bus_rdata;
            unique case (ret_q)
              P_PRE_OWN:  st_d = S_WOWN;
              P_POST_OWN: begin
                ret_d   = P_PRE_CHIP;
                pc_load = 1'b1;
                cur_d   = CW'(owner_idx);
                first_d = 1'b1;
              end
              P_PRE_CHIP:  st_d = S_WCHIP;
              P_POST_CHIP: st_d = S_RBACK;
              default:     st_d = S_IDLE;
            endcase
          end else if (pc_zero) begin
            st_d = S_IDLE; done_d = 1'b1; err_d = E_TIMEOUT;
          end else begin
            pc_dec = 1'b1;
          end
        end
      end
      S_WOWN: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = A_OWNER;
        bus_wdata = last_q | (BUS_DW'(owner_idx) << OWNER_SH);
        if (bus_ack) begin
          st_d = S_POLL; ret_d = P_POST_OWN; pc_load = 1'b1;
        end
      end
      S_WCHIP: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = desc_addr;
        bus_wdata = desc_val;
        if (bus_ack) begin
          st_d = S_POLL; ret_d = P_POST_CHIP; pc_load = 1'b1;
        end
      end
      S_RBACK: begin
        bus_req  = 1'b1;
        bus_addr = desc_addr;
        if (bus_ack) begin
          if (bus_rdata != desc_val) begin
            st_d = S_IDLE; done_d = 1'b1; err_d = E_RBACK;
          end else begin
            st_d = S_STAT1;
          end
        end
      end
      S_STAT1: begin
        bus_req  = 1'b1;
        bus_addr = A_STAT;
        if (bus_ack) begin
          if (bus_rdata[1:0] != RS_CONS) begin
            st_d = S_IDLE; done_d = 1'b1; err_d = E_INCONS;
          end else if (nxt_last) begin
            st_d = S_IDLE; done_d = 1'b1;
          end else begin
            cur_d   = nxt_idx;
            first_d = 1'b0;
            st_d    = S_POLL;
            ret_d   = P_PRE_CHIP;
            pc_load = 1'b1;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      ret_q   <= P_PRE_OWN;
      cur_q   <= '0;
      first_q <= 1'b0;
      last_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= E_NONE;
    end else begin
      st_q    <= st_d;
      ret_q   <= ret_d;
      cur_q   <= cur_d;
      first_q <= first_d;
      last_q  <= last_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign err_code = err_q;
endmodule

// File: rtl/mc_route_seq_chk.sv
module mc_route_seq_chk import mcr_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              bus_req,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              busy,
  input logic              done,
  input logic [2:0]        err_code
);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_wdata));

  a_r12_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(err_code));

  a_r12_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != E_NONE) |-> done);

  a_r7_online_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && (bus_addr >= A_CHIP0) |-> bus_wdata[0]);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  a_r12_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

bind mc_route_seq mc_route_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ack(bus_ack), .busy(busy), .done(done), .err_code(err_code)
);

// File: tb/sim_mc_route_seq.sv
module sim_mc_route_seq;
  localparam int NCH   = 4;
  localparam int SW    = 10;
  localparam int RTRY  = 4;
  localparam logic [31:0] OWN_INIT = 32'h0000_0300;

  logic clk, rst_n, start;
  logic [2:0] chip_count;
  logic [1:0] owner_idx;
  logic [NCH*16-1:0] addr_tbl;
  logic [NCH*SW-1:0] lo_tbl, hi_tbl;
  logic bus_req, bus_we, bus_ack;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic busy, done;
  logic [2:0] err_code;

  mc_route_seq #(.MAX_CHIPS(NCH), .SPI_W(SW), .RETRY(RTRY)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_count(chip_count),
    .owner_idx(owner_idx), .chip_addr_tbl(addr_tbl), .spi_lo_tbl(lo_tbl),
    .spi_hi_tbl(hi_tbl), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .err_code(err_code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk, n_bad, cyc, viol;
  int addr_a[NCH], lo_a[NCH], hi_a[NCH];

  // responder configuration (driven by the stimulus process only)
  logic        clr_log, corrupt;
  logic [31:0] ctrl_v;
  logic [1:0]  disc_v, cons_v;
  int          pup_len;

  // responder state
  int          wr_n, pup_left;
  logic        own_w;
  logic [31:0] own_reg;
  logic [11:0] la[16];
  logic [31:0] ld[16];
  logic [31:0] cmem[NCH];

  always @(posedge clk) begin
    if (!rst_n || clr_log) begin
      bus_ack  <= 1'b0;
      bus_rdata <= '0;
      wr_n     <= 0;
      own_w    <= 1'b0;
      own_reg  <= OWN_INIT;
      pup_left <= pup_len;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        if (wr_n < 16) begin la[wr_n] <= bus_addr; ld[wr_n] <= bus_wdata; end
        wr_n     <= wr_n + 1;
        pup_left <= pup_len;
        if (bus_addr == 12'h014) begin own_w <= 1'b1; own_reg <= bus_wdata; end
        else if (bus_addr >= 12'h040) cmem[(bus_addr - 12'h040) >> 2] <= bus_wdata;
      end else begin
        if (bus_addr == 12'h000) bus_rdata <= ctrl_v;
        else if (bus_addr == 12'h010) bus_rdata <= {30'd0, own_w ? cons_v : disc_v};
        else if (bus_addr == 12'h014) begin
          bus_rdata <= own_reg | {31'd0, pup_left > 0};
          if (pup_left > 0) pup_left <= pup_left - 1;
        end else
          bus_rdata <= cmem[(bus_addr - 12'h040) >> 2] ^ (corrupt ? 32'h100 : 32'h0);
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  // R11 protocol monitor, sampled at the falling edge
  logic pend_q;
  logic [11:0] pend_a;
  always @(negedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      viol   <= 0;
    end else begin
      if (pend_q && (!bus_req || bus_addr != pend_a)) viol <= viol + 1;
      pend_q <= bus_req && !bus_ack;
      pend_a <= bus_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_val(input int i);
    int lo = lo_a[i], hi = hi_a[i];
    if (lo == 0 && hi == 0) begin lo = 32; hi = 32; end
    return (addr_a[i] << 16) | (((hi - lo + 1) / 32) << 8) | (((lo - 32) / 32) << 1) | 1;
  endfunction

  task automatic set_tables(input int own, input int zero_idx);
    for (int i = 0; i < NCH; i++) begin
      addr_a[i] = 16'h0A00 + i * 16'h0111 + own;
      lo_a[i]   = 32 + 96 * i;
      hi_a[i]   = lo_a[i] + 31 + 32 * (i % 2);
      if (i == zero_idx) begin lo_a[i] = 0; hi_a[i] = 0; end
      addr_tbl[i*16 +: 16] = 16'(addr_a[i]);
      lo_tbl[i*SW +: SW]   = SW'(lo_a[i]);
      hi_tbl[i*SW +: SW]   = SW'(hi_a[i]);
    end
  endtask

  task automatic launch(input int cnt, input int own);
    @(negedge clk) clr_log = 1'b1;
    @(negedge clk) clr_log = 1'b0;
    chip_count = 3'(cnt);
    owner_idx  = 2'(own);
    start      = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic finish_run();
    while (!done) @(negedge clk);
  endtask

  task automatic reset_cfg();
    ctrl_v = '0; disc_v = 2'b00; cons_v = 2'b01; pup_len = 1; corrupt = 1'b0;
  endtask

  // watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0;
    rst_n = 1'b0; start = 1'b0; clr_log = 1'b0;
    chip_count = '0; owner_idx = '0;
    reset_cfg();
    set_tables(0, -1);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req && err_code == 0, "R1 reset state",
        {busy, done, bus_req, err_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep all counts and owner positions
    for (int cnt = 1; cnt <= NCH; cnt++) begin
      for (int own = 0; own < cnt; own++) begin
        int k;
        reset_cfg();
        pup_len = (cnt + own) % (RTRY + 1);
        set_tables(own, (cnt == 3) ? 2 : -1);
        launch(cnt, own);
        finish_run();
        chk(err_code == 0, "R6 success code", err_code, 0);
        chk(wr_n == cnt + 1, "R6 write count", wr_n, cnt + 1);
        chk(la[0] == 12'h014, "R5 owner write address", la[0], 12'h014);
        chk(ld[0] == (OWN_INIT | (own << 4)), "R5 owner write value",
            ld[0], OWN_INIT | (own << 4));
        k = 1;
        chk(la[1] == 12'(12'h040 + 4 * own), "R6 owner first", la[1], 12'h040 + 4 * own);
        chk(ld[1] == exp_val(own), "R7 owner descriptor", ld[1], exp_val(own));
        for (int i = 0; i < cnt; i++) begin
          if (i == own) continue;
          k++;
          chk(la[k] == 12'(12'h040 + 4 * i), "R6 ascending order", la[k], 12'h040 + 4 * i);
          chk(ld[k] == exp_val(i), "R7 descriptor value", ld[k], exp_val(i));
          if (lo_a[i] == 0 && hi_a[i] == 0)
            chk(ld[k] == ((addr_a[i] << 16) | 1), "R8 zero range entry",
                ld[k], (addr_a[i] << 16) | 1);
        end
      end
    end

    // R12: result held after completion
    repeat (6) @(negedge clk);
    chk(done && err_code == 0 && !busy, "R12 result held", {done, err_code}, 8);

    // R2: each blocking control bit
    for (int b = 0; b < 4; b++) begin
      reset_cfg();
      ctrl_v = 32'h1 << ((b == 3) ? 31 : b);
      launch(2, 0);
      finish_run();
      chk(err_code == 3'd1, "R2 control blocked", err_code, 1);
      chk(wr_n == 0, "R2 no write", wr_n, 0);
    end
    // control bit outside the mask is harmless
    reset_cfg(); ctrl_v = 32'h0000_0010;
    launch(2, 1); finish_run();
    chk(err_code == 0, "R2 unrelated bit", err_code, 0);

    // R3: not disconnected
    reset_cfg(); disc_v = 2'b10;
    launch(2, 0); finish_run();
    chk(err_code == 3'd2, "R3 not disconnected", err_code, 2);
    chk(wr_n == 0, "R3 no write", wr_n, 0);

    // R4: retry boundary
    reset_cfg(); pup_len = RTRY;
    launch(2, 1); finish_run();
    chk(err_code == 0, "R4 RETRY busy reads pass", err_code, 0);
    reset_cfg(); pup_len = RTRY + 1;
    launch(2, 1); finish_run();
    chk(err_code == 3'd3, "R4 timeout", err_code, 3);
    chk(wr_n == 0, "R4 no write on timeout", wr_n, 0);

    // R9: readback mismatch
    reset_cfg(); corrupt = 1'b1;
    launch(3, 1); finish_run();
    chk(err_code == 3'd4, "R9 readback mismatch", err_code, 4);
    chk(wr_n == 2, "R9 stops after first descriptor", wr_n, 2);

    // R10: inconsistent routing state
    reset_cfg(); cons_v = 2'b10;
    launch(3, 2); finish_run();
    chk(err_code == 3'd5, "R10 inconsistent", err_code, 5);
    chk(wr_n == 2, "R10 stops after first descriptor", wr_n, 2);

    // R12: new start clears, stray start while busy ignored
    reset_cfg();
    set_tables(1, -1);
    launch(4, 1);
    chk(!done && err_code == 0 && busy, "R12 start clears result",
        {done, err_code}, 0);
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    finish_run();
    chk(err_code == 0 && wr_n == 5, "R12 start while busy ignored", wr_n, 5);
    chk(ld[1] == exp_val(1), "R12 order intact", ld[1], exp_val(1));

    chk(viol == 0, "R11 request held until ack", viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule